// File: doc/BRIEF.md
# Configurable SPI Master Controller

This block is the master side of a four-wire serial link. Software programs a control register with the clock polarity, the clock phase, a two-bit rate select and a double-speed bit. It then writes a byte into the data register. The engine produces eight serial clock periods, shifts the byte out most significant bit first on `mosi`, and shifts the byte arriving on `miso` into the data register. When the eighth bit has gone, the engine raises a completion flag.

The serial clock period is taken from a fixed eight-entry table. The table is indexed by the double-speed bit together with the rate select. A slave-select input is also monitored. When its direction pin marks it as an input and it is pulled low while master mode is on, the controller leaves master mode, abandons any transfer and raises the completion flag. Software must re-enable master mode before the next transfer. All settings are captured when a transfer starts, so a register write in the middle of a byte does not disturb it.

Register map (byte-wide, `addr`): 0 = control (bit0 master enable, bit1 clock polarity, bit2 clock phase, bits4:3 rate select, bit5 double speed, bits7:6 spare, stored and read back); 1 = status (bit7 transfer complete, bit6 write collision, others 0); 2 = data (write starts a transfer, read returns the last received byte); 3 reads 0.

Top module: `spi_master_core`

## Requirements
- R1: After reset `sclk` and `mosi` are 0 and the control, status and data registers all read 0.
- R2: Whenever no transfer is running, `sclk` sits at the level of control bit1 (1 = idles high, 0 = idles low), including after the last bit of a transfer.
- R3: With clock phase (control bit2) 0, the first data bit is driven on `mosi` before the first `sclk` edge, `miso` is sampled on each leading edge and `mosi` changes on trailing edges.
- R4: With clock phase 1, `mosi` changes on each leading `sclk` edge (the first bit appears at the first edge) and `miso` is sampled on each trailing edge.
- R5: A transfer is exactly 8 `sclk` periods, most significant bit first in both directions, and the received byte reads back at address 2 once the complete flag is set.
- R6: With double speed 0, rate select 0,1,2,3 gives an `sclk` period of 4, 16, 64, 128 system clocks (a transfer lasts 8 periods from the data write to the complete flag).
- R7: With double speed 1, rate select 0,1,2,3 gives an `sclk` period of 2, 8, 32, 64 system clocks.
- R8: A data write starts a transfer only when master enable is 1 and no transfer is running; with master enable 0 it produces no `sclk` activity and no complete flag.
- R9: The complete flag (status bit7) is set at the end of each transfer. It is cleared, together with the collision flag, only by a status read made while it is set followed by a read or write of address 2. A data read without the preceding status read leaves it set.
- R10: A data write during a transfer sets the collision flag (status bit6) and changes neither the bits being shifted nor the received byte.
- R11: When master enable is 1, `ss_dir_in` is 1 and `ss_n_in` is 0, the next cycle shows master enable 0 and the complete flag set, any transfer is abandoned, and `sclk` returns to idle.
- R12: A control write during a transfer does not change that transfer's rate or clock mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (used for flag clearing) |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational on `addr` |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n_in | input | 1 | Slave-select line, active low |
| ss_dir_in | input | 1 | 1 when the slave-select pin is configured as an input |

## Verification
A data write captured on clock edge P0 has its complete flag and received byte visible after edge P0 + 8·period, and the first `sclk` toggle after edge P0 + period/2. The bench counts falling clock edges from the write and expects the flag at exactly count 8·period, for every rate setting. A mode fault and a collision are due one edge after the triggering input, and the bench reads them at the next falling edge. Serial data is checked by a slave model that follows the programmed phase on every `sclk` transition, while the design samples `miso` at least one system clock after the model changes it.

// File: rtl/spi_pkg.sv
package spi_pkg;

    localparam int HALF_W = 7;

    typedef struct packed {
        logic [1:0] spare;
        logic       dbl;
        logic [1:0] rate;
        logic       cpha;
        logic       cpol;
        logic       men;
    } ctrl_t;

    // half serial period minus one, in system clocks
    function automatic logic [HALF_W-1:0] half_minus1(input logic dbl, input logic [1:0] rate);
        logic [HALF_W:0] div;
        if (rate == 2'd3) div = dbl ? 8'd64 : 8'd128;
        else              div = (dbl ? 8'd2 : 8'd4) << {rate, 1'b0};
        return HALF_W'((div >> 1) - 8'd1);
    endfunction

endpackage

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
    parameter int HALF_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [HALF_W-1:0] half_m1,
    output logic              tick
);
    typedef struct packed {
        logic [HALF_W-1:0] cnt;
    } div_state_t;

    div_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        tick    = 1'b0;
        if (!run) begin
            state_d.cnt = half_m1;
        end else if (state_q.cnt == '0) begin
            tick        = 1'b1;
            state_d.cnt = half_m1;
        end else begin
            state_d.cnt = state_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic              tick,
    input  logic              cpha_in,
    input  logic              cpol_in,
    input  logic [DATA_W-1:0] tx_in,
    input  logic              miso,
    output logic              busy,
    output logic              sclk,
    output logic              mosi,
    output logic [DATA_W-1:0] rx,
    output logic              last_edge
);
    localparam int EDGES = 2 * DATA_W;
    localparam int EW    = $clog2(EDGES);

    typedef struct packed {
        logic              busy;
        logic              ph;
        logic              cpha;
        logic              cpol;
        logic [EW-1:0]     edge_n;
        logic [DATA_W-1:0] tx_sh;
        logic [DATA_W-1:0] rx;
        logic              mosi;
    } eng_state_t;

    eng_state_t state_d, state_q;
    logic       leading;

    always_comb begin
        state_d   = state_q;
        leading   = ~state_q.edge_n[0];
        last_edge = state_q.busy && tick && (state_q.edge_n == EW'(EDGES - 1));
        if (abort) begin
            state_d.busy = 1'b0;
            state_d.ph   = 1'b0;
        end else if (start) begin
            state_d.busy   = 1'b1;
            state_d.ph     = 1'b0;
            state_d.edge_n = '0;
            state_d.cpha   = cpha_in;
            state_d.cpol   = cpol_in;
            state_d.rx     = '0;
            if (!cpha_in) begin
                state_d.mosi  = tx_in[DATA_W-1];
                state_d.tx_sh = tx_in << 1;
            end else begin
                state_d.tx_sh = tx_in;
            end
        end else if (state_q.busy && tick) begin
            state_d.ph     = ~state_q.ph;
            state_d.edge_n = state_q.edge_n + 1'b1;
            if (leading ^ state_q.cpha) begin
                state_d.rx = {state_q.rx[DATA_W-2:0], miso};
            end else if (state_q.cpha || !last_edge) begin
                state_d.mosi  = state_q.tx_sh[DATA_W-1];
                state_d.tx_sh = state_q.tx_sh << 1;
            end
            if (last_edge) state_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign busy = state_q.busy;
    assign sclk = state_q.busy ? (state_q.cpol ^ state_q.ph) : cpol_in;
    assign mosi = state_q.mosi;
    assign rx   = state_q.rx;
endmodule

// File: rtl/spi_master_core.sv
module spi_master_core
    import spi_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    input  logic              ss_n_in,
    input  logic              ss_dir_in
);
    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_STAT = 2'd1;
    localparam logic [1:0] A_DATA = 2'd2;

    typedef struct packed {
        ctrl_t             ctrl;
        logic              done;
        logic              coll;
        logic              arm;
        logic [HALF_W-1:0] half_l;
    } core_state_t;

    core_state_t       state_d, state_q;
    logic              busy, tick, last_edge, fault, start, wr_data, data_touch;
    logic              ctrl_men, ctrl_cpol, done_flag, coll_flag;
    logic [HALF_W-1:0] half_live, half_sel;
    logic [DATA_W-1:0] rx_byte;

    assign half_live = half_minus1(state_q.ctrl.dbl, state_q.ctrl.rate);
    assign half_sel  = busy ? state_q.half_l : half_live;

    always_comb begin
        state_d    = state_q;
        wr_data    = wr_en && (addr == A_DATA);
        data_touch = (wr_en || rd_en) && (addr == A_DATA);
        fault      = state_q.ctrl.men && ss_dir_in && !ss_n_in;
        start      = wr_data && state_q.ctrl.men && !busy && !fault;

        if (wr_en && (addr == A_CTRL)) state_d.ctrl = ctrl_t'(wdata);
        if (start) state_d.half_l = half_live;

        if (rd_en && (addr == A_STAT) && state_q.done) state_d.arm = 1'b1;
        if (state_q.arm && data_touch) begin
            state_d.done = 1'b0;
            state_d.coll = 1'b0;
            state_d.arm  = 1'b0;
        end
        if (wr_data && busy) state_d.coll = 1'b1;
        if (last_edge) state_d.done = 1'b1;
        if (fault) begin
            state_d.ctrl.men = 1'b0;
            state_d.done     = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    spi_clk_div #(.HALF_W(HALF_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (busy),
        .half_m1(half_sel),
        .tick   (tick)
    );

    spi_shift_engine #(.DATA_W(DATA_W)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .abort    (fault),
        .tick     (tick),
        .cpha_in  (state_q.ctrl.cpha),
        .cpol_in  (state_q.ctrl.cpol),
        .tx_in    (wdata),
        .miso     (miso),
        .busy     (busy),
        .sclk     (sclk),
        .mosi     (mosi),
        .rx       (rx_byte),
        .last_edge(last_edge)
    );

    always_comb begin
        case (addr)
            A_CTRL:  rdata = DATA_W'(state_q.ctrl);
            A_STAT:  rdata = {state_q.done, state_q.coll, {(DATA_W-2){1'b0}}};
            A_DATA:  rdata = rx_byte;
            default: rdata = '0;
        endcase
    end

    assign ctrl_men  = state_q.ctrl.men;
    assign ctrl_cpol = state_q.ctrl.cpol;
    assign done_flag = state_q.done;
    assign coll_flag = state_q.coll;
endmodule

// File: rtl/spi_master_core_chk.sv
module spi_master_core_chk (
    input logic clk,
    input logic rst_n,
    input logic sclk,
    input logic mosi,
    input logic busy,
    input logic cpol,
    input logic men,
    input logic ss_dir_in,
    input logic ss_n_in,
    input logic done,
    input logic coll,
    input logic wr_data
);
    // R2
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sclk == cpol));

    // R11
    mode_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (men && ss_dir_in && !ss_n_in) |=> (!men && done && !busy));

    // R10
    collision_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_data) |=> coll);

    // R3
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && $stable(sclk)) |-> $stable(mosi));

    // R9
    done_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(busy) || $past(men && ss_dir_in && !ss_n_in)));
endmodule

bind spi_master_core spi_master_core_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk     (sclk),
    .mosi     (mosi),
    .busy     (busy),
    .cpol     (ctrl_cpol),
    .men      (ctrl_men),
    .ss_dir_in(ss_dir_in),
    .ss_n_in  (ss_n_in),
    .done     (done_flag),
    .coll     (coll_flag),
    .wr_data  (wr_data)
);

// File: tb/spi_master_core_bench.sv
`timescale 1ns/1ps
module spi_master_core_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       sclk, mosi;
    logic       miso = 1'b0;
    logic       ss_n_in = 1'b1, ss_dir_in = 1'b0;

    int checks = 0, fails = 0, toggles = 0;
    bit finished = 1'b0;

    bit       slv_on = 1'b0, slv_cpha = 1'b0;
    int       slv_n = 0;
    logic [7:0] slv_tx = 8'd0, slv_rx = 8'd0;

    always #2 clk = ~clk;

    spi_master_core u_spi_master_core (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .sclk(sclk), .mosi(mosi), .miso(miso),
        .ss_n_in(ss_n_in), .ss_dir_in(ss_dir_in)
    );

    always @(sclk) begin
        toggles++;
        if (slv_on) begin
            if (((slv_n % 2) == 0) ^ slv_cpha) begin
                slv_rx = {slv_rx[6:0], mosi};
            end else if (slv_cpha) begin
                miso = slv_tx[7 - slv_n/2];
            end else if (slv_n/2 < 7) begin
                miso = slv_tx[6 - slv_n/2];
            end
            slv_n++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0; addr = 2'd1;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rdata;
        @(negedge clk); rd_en = 1'b0; addr = 2'd1;
    endtask

    task automatic clear_flags();
        logic [7:0] v;
        rd(2'd1, v);
        rd(2'd2, v);
    endtask

    function automatic int exp_div(input logic dbl, input logic [1:0] rate);
        case ({dbl, rate})
            3'b000: return 4;   3'b001: return 16;
            3'b010: return 64;  3'b011: return 128;
            3'b100: return 2;   3'b101: return 8;
            3'b110: return 32;  default: return 64;
        endcase
    endfunction

    // one transfer; optional register write at fall count mid_at
    task automatic xfer(input string ctag, input logic [7:0] ctrl, input logic [7:0] tx,
                        input logic [7:0] slv, input int exp_cyc, input int mid_at,
                        input logic [1:0] mid_a, input logic [7:0] mid_d);
        logic [7:0] v;
        int n;
        bit got;
        wr(2'd0, ctrl);
        clear_flags();
        slv_cpha = ctrl[2]; slv_tx = slv; slv_rx = 8'd0; slv_n = 0;
        miso = ctrl[2] ? 1'b0 : slv[7];
        slv_on = 1'b1;
        wr(2'd2, tx);
        n = 0; got = 1'b0;
        while (!got && n < 3000) begin
            @(negedge clk); n++;
            if (n == mid_at) begin addr = mid_a; wdata = mid_d; wr_en = 1'b1; end
            else begin
                if (n == mid_at + 1) begin wr_en = 1'b0; addr = 2'd1; end
                #1 got = rdata[7];
            end
        end
        slv_on = 1'b0;
        chk(n == exp_cyc, ctag, n, exp_cyc);
        rd(2'd2, v);
        chk(v == slv, "R5 received byte", v, slv);
        chk(slv_rx == tx, ctrl[2] ? "R4 slave capture" : "R3 slave capture", slv_rx, tx);
        chk(sclk == ctrl[1], "R2 idle level after transfer", sclk, ctrl[1]);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk(sclk == 1'b0 && mosi == 1'b0, "R1 sclk/mosi", {sclk, mosi}, 0);
        rd(2'd0, v); chk(v == 8'd0, "R1 control", v, 0);
        rd(2'd1, v); chk(v == 8'd0, "R1 status", v, 0);
        rd(2'd2, v); chk(v == 8'd0, "R1 data", v, 0);
    endtask

    task automatic t_modes();
        xfer("R5 mode00 cycles", 8'h01, 8'hA5, 8'h3C, 32, -1, 2'd0, 8'd0);
        xfer("R5 mode01 cycles", 8'h05, 8'h96, 8'hC3, 32, -1, 2'd0, 8'd0);
        xfer("R5 mode10 cycles", 8'h03, 8'h81, 8'h7E, 32, -1, 2'd0, 8'd0);
        xfer("R5 mode11 cycles", 8'h07, 8'h5A, 8'h01, 32, -1, 2'd0, 8'd0);
    endtask

    task automatic t_rates();
        for (int i = 0; i < 8; i++) begin
            logic [7:0] c;
            c = {2'b00, i[2], i[1:0], 3'b001};
            xfer(i[2] ? "R7 divisor" : "R6 divisor", c, 8'(8'h11 * i + 3),
                 8'(8'hF0 - i), 8 * exp_div(i[2], i[1:0]), -1, 2'd0, 8'd0);
        end
    endtask

    task automatic t_start_gate();
        logic [7:0] v;
        wr(2'd0, 8'h00);
        clear_flags();
        toggles = 0;
        wr(2'd2, 8'hFF);
        repeat (40) @(negedge clk);
        chk(toggles == 0, "R8 no sclk with master off", toggles, 0);
        rd(2'd1, v); chk(v[7] == 1'b0, "R8 no complete flag", v[7], 0);
    endtask

    task automatic t_clear();
        logic [7:0] v;
        xfer("R5 pre-clear cycles", 8'h01, 8'h12, 8'h34, 32, -1, 2'd0, 8'd0);
        rd(2'd1, v); chk(v[7] == 1'b1, "R9 flag set at end", v[7], 1);
        clear_flags();
        xfer("R5 pre-clear cycles", 8'h01, 8'h12, 8'h34, 32, -1, 2'd0, 8'd0);
        rd(2'd2, v);
        rd(2'd1, v); chk(v[7] == 1'b1, "R9 data read alone keeps flag", v[7], 1);
        rd(2'd2, v);
        rd(2'd1, v); chk(v[7] == 1'b0, "R9 status then data clears", v[7], 0);
    endtask

    task automatic t_collision();
        logic [7:0] v;
        xfer("R10 cycles", 8'h01, 8'hC6, 8'h6C, 32, 10, 2'd2, 8'hFF);
        rd(2'd1, v); chk(v[6] == 1'b1, "R10 collision flag", v[6], 1);
    endtask

    task automatic t_cfg_latch();
        xfer("R12 rate kept", 8'h01, 8'h3A, 8'hA3, 32, 6, 2'd0, 8'h19);
    endtask

    task automatic t_fault();
        logic [7:0] v;
        wr(2'd0, 8'h03);
        clear_flags();
        wr(2'd2, 8'h55);
        repeat (9) @(negedge clk);
        ss_dir_in = 1'b1; ss_n_in = 1'b0;
        @(negedge clk);
        ss_n_in = 1'b1;
        #1 chk(sclk == 1'b1, "R11 sclk idle after fault", sclk, 1);
        rd(2'd0, v); chk(v[0] == 1'b0, "R11 master enable cleared", v[0], 0);
        rd(2'd1, v); chk(v[7] == 1'b1, "R11 complete flag set", v[7], 1);
        toggles = 0;
        wr(2'd2, 8'hAA);
        repeat (30) @(negedge clk);
        chk(toggles == 0, "R11 no transfer until re-enabled", toggles, 0);
        ss_dir_in = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_modes();
        t_rates();
        t_start_gate();
        t_clear();
        t_collision();
        t_cfg_latch();
        t_fault();
        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        summary();
    end
endmodule